// File: doc/BRIEF.md
# Dual-Style Host Parallel Port

This block is the host-facing parallel port of a character display controller. A host processor reaches the controller through a register-select line, an eight-bit data bus and one of two strobe styles. A static mode pin picks the style. In the enable style, one enable strobe is qualified by a read/write level. In the split style, two separate active-low strobes are used, one for read and one for write. The register-select line chooses between the instruction path and the data path, for writes and for reads alike.

Each completed host write becomes a one-cycle byte pulse towards the command engine, on the instruction path or the data path. A completed data read raises a one-cycle request so that the engine can advance to the next address. Reads drive either the status byte or the engine's read data onto the bus, through a data/enable pair that feeds the pad tri-state. The bus can run eight bits at a time or four bits at a time. In the four-bit case only the upper lanes are used, each byte needs two transfers, and the upper nibble comes first. The width follows the interface bit of every accepted function-set instruction.

Top module: `host_bus_port`

## Requirements
- R1: With `mode_intel`=0, `hb_strb_a` is an active-high enable and `hb_strb_b` is a read/write level (1 = read). A write is taken when the enable falls while the level is 0. A read is in progress while the enable is high and the level is 1. With `mode_intel`=1, `hb_strb_a` is an active-low read strobe and `hb_strb_b` is an active-low write strobe. A write is taken when the write strobe rises.
- R2: A completed write with `hb_rs`=0 gives a one-cycle `cmd_valid` pulse with the byte on `cmd_byte`. With `hb_rs`=1 it gives a one-cycle `dat_valid` pulse with the byte on `dat_byte`. Both are due three clocks after the strobe edge reaches the pins.
- R3: A read with `hb_rs`=0 returns `core_busy` on bit 7 and `core_addr` on bits 6..0.
- R4: A read with `hb_rs`=1 returns `core_rdata`. After a data read is complete (the second nibble in four-bit mode), `rd_req` pulses for one cycle, three clocks after the strobe is released. Status reads give no `rd_req`.
- R5: In four-bit mode, writes take `hb_d_in[7:4]` only, upper nibble first, and the assembled byte is issued after the second transfer. Reads place the upper nibble, then the lower nibble, on `hb_d_out[7:4]` with bits 3..0 at 0.
- R6: After reset the bus is eight bits wide. An accepted instruction whose bits 7..5 are 001 sets the width from bit 4 (1 = eight bits, 0 = four bits).
- R7: An instruction byte completed while `core_busy`=1 is dropped. It gives no `cmd_valid` and causes no width change. Data writes are passed on regardless of busy.
- R8: The nibble phase returns to the upper nibble on reset and whenever the width changes.
- R9: `hb_d_oe` is 1 only during a read strobe of the selected style. It rises three clocks after the strobe becomes active and falls three clocks after the strobe is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_intel | input | 1 | Static strobe style: 0 enable + read/write level, 1 split read/write strobes |
| hb_strb_a | input | 1 | Enable (style 0) or active-low read strobe (style 1) |
| hb_strb_b | input | 1 | Read/write level (style 0) or active-low write strobe (style 1) |
| hb_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| hb_d_in | input | 8 | Host data bus, input side |
| hb_d_out | output | 8 | Host data bus, output side |
| hb_d_oe | output | 1 | Output enable for the data bus pads |
| core_busy | input | 1 | Busy level from the command engine |
| core_addr | input | 7 | Address counter from the command engine |
| core_rdata | input | 8 | Read data from the command engine |
| cmd_valid | output | 1 | Instruction byte pulse |
| cmd_byte | output | 8 | Instruction byte |
| dat_valid | output | 1 | Data byte pulse |
| dat_byte | output | 8 | Data byte |
| rd_req | output | 1 | Data read completed, advance request |

## Verification
Every result lags the pins by three clocks: two synchroniser stages and one output register. Byte pulses and `rd_req` fall due three clocks after the closing strobe edge. The output enable and read data fall due three clocks after the strobe turns on or off. The bench model records each expected pulse under the cycle number in which it is due, and compares the pulse outputs at every falling clock edge. A pulse that comes early, comes late or is missing counts as a failure. Read windows are probed exactly one cycle before and at the due cycle, so the three-clock latency is pinned down in both directions.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int RAW_W  = BYTE_W + 3;

    typedef struct packed {
        logic              rd_on;
        logic              wr_on;
        logic              rs;
        logic [BYTE_W-1:0] data;
    } bus_view_t;

    function automatic logic is_func_set(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:BYTE_W-3] == 3'b001;
    endfunction

    function automatic logic [BYTE_W-1:0] place_nibble(input logic [BYTE_W-1:0] b,
                                                        input logic upper);
        return upper ? {b[BYTE_W-1:NIB_W], {NIB_W{1'b0}}}
                     : {b[NIB_W-1:0],      {NIB_W{1'b0}}};
    endfunction
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] idle_val,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= idle_val;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/hbp_decode.sv
module hbp_decode
    import hbp_pkg::*;
(
    input  logic              mode_intel,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              rs,
    input  logic [BYTE_W-1:0] data,
    output bus_view_t         view
);
    always_comb begin
        view.rs   = rs;
        view.data = data;
        if (mode_intel) begin
            view.rd_on = !pin_a;
            view.wr_on = !pin_b;
        end else begin
            view.rd_on = pin_a & pin_b;
            view.wr_on = pin_a & !pin_b;
        end
    end
endmodule

// File: rtl/hbp_nibble.sv
module hbp_nibble
    import hbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_end,
    input  logic              rd_end,
    input  logic              rs,
    input  logic [BYTE_W-1:0] data,
    input  logic              core_busy,
    output logic              width8,
    output logic              phase_hi,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              dat_valid,
    output logic [BYTE_W-1:0] dat_byte,
    output logic              rd_req
);
    logic [NIB_W-1:0]  hi_q;
    logic              byte_done;
    logic [BYTE_W-1:0] full_byte;
    logic              take_cmd;
    logic              width_chg;

    always_comb begin
        byte_done = width8 | !phase_hi;
        full_byte = width8 ? data : {hi_q, data[BYTE_W-1:NIB_W]};
        take_cmd  = wr_end & byte_done & !rs & !core_busy;
        width_chg = take_cmd & is_func_set(full_byte) & (full_byte[NIB_W] != width8);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            width8    <= 1'b1;
            phase_hi  <= 1'b1;
            hi_q      <= '0;
            cmd_valid <= 1'b0;
            cmd_byte  <= '0;
            dat_valid <= 1'b0;
            dat_byte  <= '0;
            rd_req    <= 1'b0;
        end else begin
            cmd_valid <= take_cmd;
            dat_valid <= wr_end & byte_done & rs;
            rd_req    <= rd_end & byte_done & rs;
            if (take_cmd) cmd_byte <= full_byte;
            if (wr_end & byte_done & rs) dat_byte <= full_byte;
            if (wr_end & !width8 & phase_hi) hi_q <= data[BYTE_W-1:NIB_W];
            if (width_chg) begin
                width8   <= full_byte[NIB_W];
                phase_hi <= 1'b1;
            end else if ((wr_end | rd_end) & !width8) begin
                phase_hi <= !phase_hi;
            end
        end
    end

    p_busy_drop_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !$past(core_busy));
    p_one_sink_r2: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && dat_valid));
    p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);
    p_lowphase_r5: assert property (@(posedge clk) disable iff (rst)
        (dat_valid && !width8) |-> phase_hi);
    p_width_phase_r8: assert property (@(posedge clk) disable iff (rst)
        (width8 != $past(width8)) |-> phase_hi);
endmodule

// File: rtl/hbp_readout.sv
module hbp_readout
    import hbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_on,
    input  logic              rs,
    input  logic              width8,
    input  logic              phase_hi,
    input  logic              core_busy,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [BYTE_W-1:0] core_rdata,
    output logic [BYTE_W-1:0] d_out,
    output logic              d_oe
);
    logic [BYTE_W-1:0] src;
    logic [BYTE_W-1:0] lane;

    always_comb begin
        src  = rs ? core_rdata : {core_busy, core_addr};
        lane = width8 ? src : place_nibble(src, phase_hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_oe  <= 1'b0;
            d_out <= '0;
        end else begin
            d_oe  <= rd_on;
            d_out <= rd_on ? lane : '0;
        end
    end

    p_quiet_bus_r9: assert property (@(posedge clk) disable iff (rst)
        !d_oe |-> (d_out == '0));
endmodule

// File: rtl/host_bus_port.sv
module host_bus_port
    import hbp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_intel,
    input  logic              hb_strb_a,
    input  logic              hb_strb_b,
    input  logic              hb_rs,
    input  logic [BYTE_W-1:0] hb_d_in,
    output logic [BYTE_W-1:0] hb_d_out,
    output logic              hb_d_oe,
    input  logic              core_busy,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [BYTE_W-1:0] core_rdata,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              dat_valid,
    output logic [BYTE_W-1:0] dat_byte,
    output logic              rd_req
);
    logic [RAW_W-1:0] raw_in, raw_idle, raw_s;
    bus_view_t        cur, prv;
    logic             wr_end, rd_end;
    logic             width8, phase_hi;

    assign raw_in   = {hb_strb_a, hb_strb_b, hb_rs, hb_d_in};
    assign raw_idle = {mode_intel, 1'b1, 1'b0, {BYTE_W{1'b0}}};

    hbp_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .idle_val(raw_idle), .d(raw_in), .q(raw_s)
    );

    hbp_decode u_decode (
        .mode_intel(mode_intel),
        .pin_a(raw_s[RAW_W-1]),
        .pin_b(raw_s[RAW_W-2]),
        .rs(raw_s[BYTE_W]),
        .data(raw_s[BYTE_W-1:0]),
        .view(cur)
    );

    always_ff @(posedge clk) begin
        if (rst) prv <= '0;
        else     prv <= cur;
    end

    assign wr_end = prv.wr_on & !cur.wr_on;
    assign rd_end = prv.rd_on & !cur.rd_on;

    hbp_nibble u_nibble (
        .clk(clk), .rst(rst), .wr_end(wr_end), .rd_end(rd_end),
        .rs(prv.rs), .data(prv.data), .core_busy(core_busy),
        .width8(width8), .phase_hi(phase_hi),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .dat_valid(dat_valid), .dat_byte(dat_byte), .rd_req(rd_req)
    );

    hbp_readout u_readout (
        .clk(clk), .rst(rst), .rd_on(cur.rd_on), .rs(cur.rs),
        .width8(width8), .phase_hi(phase_hi), .core_busy(core_busy),
        .core_addr(core_addr), .core_rdata(core_rdata),
        .d_out(hb_d_out), .d_oe(hb_d_oe)
    );

    p_rdreq_after_oe_r4: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> $past(hb_d_oe));
    p_no_write_in_read_r1: assert property (@(posedge clk) disable iff (rst)
        hb_d_oe |-> !dat_valid);
endmodule

// File: tb/test_host_bus_port.sv
module test_host_bus_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_intel = 1'b0;
    logic       hb_strb_a = 1'b0;
    logic       hb_strb_b = 1'b1;
    logic       hb_rs = 1'b0;
    logic [7:0] hb_d_in = 8'h00;
    logic [7:0] hb_d_out;
    logic       hb_d_oe;
    logic       core_busy = 1'b0;
    logic [6:0] core_addr = 7'h00;
    logic [7:0] core_rdata = 8'h00;
    logic       cmd_valid, dat_valid, rd_req;
    logic [7:0] cmd_byte, dat_byte;

    host_bus_port i_host_bus_port (
        .clk(clk), .rst(rst), .mode_intel(mode_intel),
        .hb_strb_a(hb_strb_a), .hb_strb_b(hb_strb_b), .hb_rs(hb_rs),
        .hb_d_in(hb_d_in), .hb_d_out(hb_d_out), .hb_d_oe(hb_d_oe),
        .core_busy(core_busy), .core_addr(core_addr), .core_rdata(core_rdata),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .dat_valid(dat_valid), .dat_byte(dat_byte), .rd_req(rd_req)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // reference model state
    bit         m_w8 = 1'b1;
    bit         m_hi_ph = 1'b1;
    logic [3:0] m_hi = 4'h0;
    logic [7:0] exp_cmd [int];
    logic [7:0] exp_dat [int];
    bit         exp_rdq [int];
    string      tag_cmd [int];
    string      tag_dat [int];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, expv, cyc);
        end
    endtask

    // per-clock comparison of pulse outputs against the model's schedule
    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid || exp_cmd.exists(cyc)) begin
                if (exp_cmd.exists(cyc)) begin
                    chk(cmd_valid && cmd_byte == exp_cmd[cyc], tag_cmd[cyc], "cmd pulse",
                        {cmd_valid, cmd_byte}, {1'b1, exp_cmd[cyc]});
                    exp_cmd.delete(cyc);
                end else chk(1'b0, "R7", "unexpected cmd pulse", cmd_byte, 0);
            end
            if (dat_valid || exp_dat.exists(cyc)) begin
                if (exp_dat.exists(cyc)) begin
                    chk(dat_valid && dat_byte == exp_dat[cyc], tag_dat[cyc], "data pulse",
                        {dat_valid, dat_byte}, {1'b1, exp_dat[cyc]});
                    exp_dat.delete(cyc);
                end else chk(1'b0, "R2", "unexpected data pulse", dat_byte, 0);
            end
            if (rd_req || exp_rdq.exists(cyc)) begin
                chk(rd_req && exp_rdq.exists(cyc), "R4", "rd_req pulse",
                    rd_req, exp_rdq.exists(cyc));
                if (exp_rdq.exists(cyc)) exp_rdq.delete(cyc);
            end
        end
    end

    function automatic void model_write(input bit rs, input logic [7:0] lanes,
                                        input int due, input string tag);
        bit done = m_w8 || !m_hi_ph;
        logic [7:0] full = m_w8 ? lanes : {m_hi, lanes[7:4]};
        bit chg = 1'b0;
        if (!m_w8 && m_hi_ph) m_hi = lanes[7:4];
        if (done) begin
            if (rs) begin
                exp_dat[due] = full; tag_dat[due] = tag;
            end else if (!core_busy) begin
                exp_cmd[due] = full; tag_cmd[due] = tag;
                if (full[7:5] == 3'b001 && full[4] != m_w8) begin
                    m_w8 = full[4]; m_hi_ph = 1'b1; chg = 1'b1;
                end
            end
        end
        if (!chg && !m_w8) m_hi_ph = !m_hi_ph;
    endfunction

    task automatic xfer_wr(input bit rs, input logic [7:0] lanes, input string tag);
        @(negedge clk);
        hb_rs = rs; hb_d_in = lanes;
        if (!mode_intel) hb_strb_b = 1'b0;
        @(negedge clk);
        if (mode_intel) hb_strb_b = 1'b0; else hb_strb_a = 1'b1;
        repeat (3) @(negedge clk);
        if (mode_intel) hb_strb_b = 1'b1; else hb_strb_a = 1'b0;
        model_write(rs, lanes, cyc + 3, tag);
        repeat (4) @(negedge clk);
        hb_strb_b = 1'b1;
    endtask

    task automatic xfer_rd(input bit rs, input logic [7:0] expv, input string tag);
        bit done;
        @(negedge clk);
        hb_rs = rs;
        if (!mode_intel) hb_strb_b = 1'b1;
        @(negedge clk);
        if (mode_intel) hb_strb_a = 1'b0; else hb_strb_a = 1'b1;
        repeat (2) @(negedge clk);
        chk(hb_d_oe == 1'b0, "R9", "oe one cycle early", hb_d_oe, 0);
        @(negedge clk);
        chk(hb_d_oe == 1'b1, "R9", "oe at due cycle", hb_d_oe, 1);
        chk(hb_d_out == expv, tag, "read lanes", hb_d_out, expv);
        @(negedge clk);
        if (mode_intel) hb_strb_a = 1'b1; else hb_strb_a = 1'b0;
        done = m_w8 || !m_hi_ph;
        if (rs && done) exp_rdq[cyc + 3] = 1'b1;
        if (!m_w8) m_hi_ph = !m_hi_ph;
        repeat (2) @(negedge clk);
        chk(hb_d_oe == 1'b1, "R9", "oe held until due", hb_d_oe, 1);
        @(negedge clk);
        chk(hb_d_oe == 1'b0, "R9", "oe released", hb_d_oe, 0);
        @(negedge clk);
    endtask

    task automatic host_write(input bit rs, input logic [7:0] b, input string tag);
        if (m_w8) xfer_wr(rs, b, tag);
        else begin
            xfer_wr(rs, {b[7:4], 4'hA}, tag);
            xfer_wr(rs, {b[3:0], 4'h5}, tag);
        end
    endtask

    task automatic host_read(input bit rs, input string tag);
        logic [7:0] src = rs ? core_rdata : {core_busy, core_addr};
        if (m_w8) xfer_rd(rs, src, tag);
        else begin
            xfer_rd(rs, {src[7:4], 4'h0}, tag);
            xfer_rd(rs, {src[3:0], 4'h0}, tag);
        end
    endtask

    task automatic do_reset(input bit intel);
        @(negedge clk);
        rst = 1'b1; mode_intel = intel;
        hb_strb_a = intel; hb_strb_b = 1'b1; hb_rs = 1'b0; hb_d_in = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_w8 = 1'b1; m_hi_ph = 1'b1;
        @(negedge clk);
        chk(!hb_d_oe && hb_d_out == 8'h00 && !cmd_valid && !dat_valid && !rd_req,
            "R6", "reset state", {hb_d_oe, hb_d_out}, 0);
    endtask

    task automatic run_suite(input bit intel);
        do_reset(intel);
        core_busy = 1'b0;
        host_write(1'b0, 8'h01, "R1");
        host_write(1'b1, 8'h41, "R2");
        core_addr = 7'h25; host_read(1'b0, "R3");
        core_busy = 1'b1; core_addr = 7'h7F; host_read(1'b0, "R3");
        core_busy = 1'b0; core_rdata = 8'h5A; host_read(1'b1, "R4");
        core_busy = 1'b1;
        host_write(1'b0, 8'h0C, "R7");
        host_write(1'b1, 8'h33, "R7");
        host_write(1'b0, 8'h20, "R7");
        core_busy = 1'b0;
        host_write(1'b1, 8'h77, "R6");
        host_write(1'b0, 8'h28, "R6");
        host_write(1'b0, 8'h0F, "R5");
        host_write(1'b1, 8'hC3, "R5");
        core_addr = 7'h4A; host_read(1'b0, "R5");
        core_rdata = 8'h9E; host_read(1'b1, "R4");
        core_busy = 1'b1; host_write(1'b0, 8'h06, "R7");
        core_busy = 1'b0;
        host_write(1'b0, 8'h30, "R8");
        host_write(1'b1, 8'hAB, "R8");
        // leave the phase on the lower nibble, then reset
        host_write(1'b0, 8'h20, "R6");
        xfer_wr(1'b1, 8'hE0, "R8");
        do_reset(intel);
        host_write(1'b1, 8'h12, "R6");
        host_write(1'b0, 8'h20, "R6");
        host_write(1'b1, 8'h34, "R8");
        repeat (6) @(negedge clk);
        chk(exp_cmd.num() == 0 && exp_dat.num() == 0 && exp_rdq.num() == 0, "R2",
            "pending pulses", exp_cmd.num() + exp_dat.num() + exp_rdq.num(), 0);
    endtask

    initial begin
        run_suite(1'b0);
        run_suite(1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule